// File: doc/BRIEF.md
# Field-Rate Vertical Flywheel with Sync Confidence Grading

This block rebuilds a clean vertical sync from a noisy separated vertical sync. A half-line strobe (two strobes per video line) drives a position counter. A five-state controller uses that counter to decide, once per field, where the next vertical pulse belongs. An up/down confidence counter records how often the incoming vertical sync has landed inside the expected window. At high confidence the block runs free as a flywheel and makes its own pulse. At medium confidence it accepts a sync only inside a narrow window. At low confidence it accepts any sync and also works out whether the source is a 50 Hz or a 60 Hz source.

The block sits behind a sync separator and ahead of the deflection timing. The line-lock flag and two control bits (a forced field rate and a hold-in-wide-search bit) come from elsewhere in the chip. All pins are plain control and status signals with no streaming data, so no valid/ready handshake is used and no back-pressure exists. Every input is sampled on the rising clock edge. The position counter, the sync edge detector and the controller only act on clocks where the half-line strobe is high.

Top module: `vdiv_norm`

## Requirements
- R1: The position counter advances by one on each clock where `line2x_en` is high, and nothing advances otherwise. A vertical sync event is a rising edge of `vsync_in` seen across two consecutive strobes. `vsync_out` is high for exactly one clock, in the clock right after a strobe that ends a field.
- R2: In the first strobe where the counter reads 488, the controller chooses the next state from the confidence level: flywheel (level >= 12), windowed (level 6 to 11) or wide search (level below 6). In flywheel state the field ends by itself when the counter reaches 626 (50 Hz) or 526 (60 Hz). The controller then waits one strobe and restarts the counter at zero. With no input sync, two flywheel fields in a row are 628 strobes apart.
- R3: In windowed state, a sync with 622 < count < 628 (50 Hz) or 522 < count < 528 (60 Hz) ends the field. Syncs outside the window are ignored. When the counter reaches 628 or 528 the field ends with an immediate counter restart. This gives an interval of 630 strobes after a flywheel field and 629 strobes after another timeout.
- R4: In wide-search state any sync ends the field. Without a sync, the field times out at 722 (50 Hz) or 576 (60 Hz) when line lock is present. Without line lock it times out at 628 or 528. A run of locked 50 Hz timeouts is 723 strobes apart, and a run of unlocked ones is 629 strobes apart (529 at 60 Hz).
- R5: A sync that ends a field restarts the counter one strobe (half a line) later. A steady sync every P strobes is therefore seen at count P-2: P = 625 lands inside the 50 Hz window and P = 624 lands outside it.
- R6: Each field end grades the field. A good field raises the 4-bit level by 1, saturating at 15. A bad field lowers it by 2 when the level is 12 or more, and by 1 otherwise, flooring at 0. `norm_lock` is high exactly when the level is 12 or more. A flywheel field is good when an in-window sync arrived before or at its end.
- R7: The first good field after one or more bad fields is graded bad.
- R8: While `hlock` is low or `wide_hold` is high, the level is forced to 0 and `norm_lock` is low from the next clock on.
- R9: While `rate_force` is high, `field_50hz` follows `rate_force_50hz` (1 = 50 Hz) from the next clock on. Detected syncs do not change it.
- R10: When the rate is not forced, a sync accepted in wide-search state selects 60 Hz if it arrives at a count below 576 and 50 Hz otherwise. A sync that changes the rate grades its field bad. After reset the rate is 50 Hz and the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line2x_en | input | 1 | Half-line strobe, two per video line |
| vsync_in | input | 1 | Separated vertical sync level |
| hlock | input | 1 | Horizontal loop locked |
| rate_force | input | 1 | Force the field rate |
| rate_force_50hz | input | 1 | Forced rate: 1 = 50 Hz, 0 = 60 Hz |
| wide_hold | input | 1 | Hold the confidence level at wide search |
| vsync_out | output | 1 | Regenerated vertical pulse, one clock wide |
| field_50hz | output | 1 | Current field rate, 1 = 50 Hz |
| norm_lock | output | 1 | Flywheel confidence reached |

## Verification
The checker watches the cycle-level rules on every clock. These are the one-clock width of `vsync_out` and its tie to a strobe, `norm_lock` dropping after lost lock or the hold bit, the forced rate reaching `field_50hz`, and `norm_lock` only ever rising together with a field end. It also checks that `norm_lock` does not move at all between field ends. Only the bench's scenarios can show the field-level arithmetic. That covers how many steady fields it takes to reach flywheel confidence, the penalty on the first good field after a bad one, and where the window edges fall given the half-line restart. It also covers the exact intervals of flywheel, windowed and wide-search timeouts once the input sync disappears.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

  typedef enum logic [2:0] {
    ST_COUNT  = 3'd0,
    ST_NORM   = 3'd1,
    ST_NEAR   = 3'd2,
    ST_NONORM = 3'd3,
    ST_WAIT   = 3'd4
  } vd_state_e;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_NEAR = 2'd1,
    GR_NORM = 2'd2
  } vd_grade_e;

endpackage

// File: rtl/vdiv_vsync_edge.sv
module vdiv_vsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vsync_in,
  output logic ev
);

  logic prev_q;

  // rising edge across consecutive strobes only
  assign ev = en && vsync_in && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (en) begin
      prev_q <= vsync_in;
    end
  end

endmodule

// File: rtl/vdiv_line_ctr.sv
module vdiv_line_ctr #(
  parameter int LC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr_now,
  input  logic            clr_late,
  output logic [LC_W-1:0] lc
);

  localparam logic [LC_W-1:0] LC_TOP = {LC_W{1'b1}};

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc     <= '0;
      pend_q <= 1'b0;
    end else if (en) begin
      if (clr_now || pend_q) begin
        lc <= '0;
      end else if (lc != LC_TOP) begin
        lc <= lc + 1'b1;
      end
      // a sync-driven restart lands half a line (one strobe) later
      pend_q <= clr_late;
    end
  end

endmodule

// File: rtl/vdiv_norm_grader.sv
module vdiv_norm_grader
  import vdiv_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int NORM_MIN = 12,
  parameter int NEAR_MIN = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      good,
  input  logic      hlock,
  input  logic      wide_hold,
  output vd_grade_e grade,
  output logic      norm_lock
);

  localparam logic [CNT_W-1:0] LVL_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LVL_NORM = CNT_W'(NORM_MIN);
  localparam logic [CNT_W-1:0] LVL_NEAR = CNT_W'(NEAR_MIN);

  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] step_dn;
  logic             last_bad_q;
  logic             credit;

  assign credit  = good && !last_bad_q;
  assign step_dn = (level_q >= LVL_NORM) ? CNT_W'(2) : CNT_W'(1);

  always_comb begin
    if (level_q >= LVL_NORM)      grade = GR_NORM;
    else if (level_q >= LVL_NEAR) grade = GR_NEAR;
    else                          grade = GR_NONE;
  end

  assign norm_lock = (level_q >= LVL_NORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= '0;
      last_bad_q <= 1'b0;
    end else if (!hlock || wide_hold) begin
      level_q    <= '0;
      last_bad_q <= 1'b0;
    end else if (fire) begin
      if (credit) begin
        if (level_q != LVL_MAX) level_q <= level_q + 1'b1;
      end else begin
        level_q <= (level_q > step_dn) ? (level_q - step_dn) : '0;
      end
      // a bad field arms the penalty, the penalised good field disarms it
      last_bad_q <= !good;
    end
  end

endmodule

// File: rtl/vdiv_ctrl.sv
module vdiv_ctrl
  import vdiv_pkg::*;
#(
  parameter int LC_W        = 10,
  parameter int COUNT_EXIT  = 488,
  parameter int NORM_AT_50  = 626,
  parameter int NORM_AT_60  = 526,
  parameter int WIN_LO_50   = 622,
  parameter int WIN_HI_50   = 628,
  parameter int WIN_LO_60   = 522,
  parameter int WIN_HI_60   = 528,
  parameter int TO_LOCK_50  = 722,
  parameter int TO_LOCK_60  = 576,
  parameter int RATE_SPLIT  = 576
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ev,
  input  logic [LC_W-1:0] lc,
  input  vd_grade_e       grade,
  input  logic            hlock,
  input  logic            rate_force,
  input  logic            rate_force_50hz,
  output logic            clr_now,
  output logic            clr_late,
  output logic            fire,
  output logic            good,
  output logic            vsync_out,
  output logic            field_50hz
);

  localparam logic [LC_W-1:0] C_EXIT  = LC_W'(COUNT_EXIT);
  localparam logic [LC_W-1:0] C_SPLIT = LC_W'(RATE_SPLIT);

  // per-rate constants: index 1 = 50 Hz, index 0 = 60 Hz
  logic [LC_W-1:0] norm_at_tab [2];
  logic [LC_W-1:0] win_lo_tab  [2];
  logic [LC_W-1:0] win_hi_tab  [2];
  logic [LC_W-1:0] to_lock_tab [2];

  for (genvar r = 0; r < 2; r++) begin : g_rate
    assign norm_at_tab[r] = LC_W'((r == 1) ? NORM_AT_50 : NORM_AT_60);
    assign win_lo_tab[r]  = LC_W'((r == 1) ? WIN_LO_50  : WIN_LO_60);
    assign win_hi_tab[r]  = LC_W'((r == 1) ? WIN_HI_50  : WIN_HI_60);
    assign to_lock_tab[r] = LC_W'((r == 1) ? TO_LOCK_50 : TO_LOCK_60);
  end

  vd_state_e       st_q, st_n;
  logic            seen_q, seen_n;
  logic            pick_vld, rate_pick;
  logic [LC_W-1:0] norm_at, win_lo, win_hi, to_lim;
  logic            in_win, late_half;

  always_comb begin
    norm_at   = norm_at_tab[field_50hz];
    win_lo    = win_lo_tab[field_50hz];
    win_hi    = win_hi_tab[field_50hz];
    to_lim    = hlock ? to_lock_tab[field_50hz] : win_hi_tab[field_50hz];
    in_win    = (lc > win_lo) && (lc < win_hi);
    late_half = (lc >= C_SPLIT);
  end

  always_comb begin
    st_n      = st_q;
    seen_n    = seen_q;
    clr_now   = 1'b0;
    clr_late  = 1'b0;
    fire      = 1'b0;
    good      = 1'b0;
    pick_vld  = 1'b0;
    rate_pick = field_50hz;
    if (en) begin
      unique case (st_q)
        ST_COUNT: begin
          if (lc == C_EXIT) begin
            seen_n = 1'b0;
            unique case (grade)
              GR_NORM: st_n = ST_NORM;
              GR_NEAR: st_n = ST_NEAR;
              default: st_n = ST_NONORM;
            endcase
          end
        end
        ST_NORM: begin
          if (ev && in_win) seen_n = 1'b1;
          if (lc >= norm_at) begin
            fire = 1'b1;
            good = seen_q || (ev && in_win);
            st_n = ST_WAIT;
          end
        end
        ST_WAIT: begin
          clr_now = 1'b1;
          st_n    = ST_COUNT;
        end
        ST_NEAR: begin
          if (ev && in_win) begin
            fire     = 1'b1;
            good     = 1'b1;
            clr_late = 1'b1;
            st_n     = ST_COUNT;
          end else if (lc >= win_hi) begin
            fire    = 1'b1;
            clr_now = 1'b1;
            st_n    = ST_COUNT;
          end
        end
        ST_NONORM: begin
          if (ev) begin
            fire      = 1'b1;
            pick_vld  = !rate_force;
            rate_pick = late_half;
            good      = in_win && (rate_force || (late_half == field_50hz));
            clr_late  = 1'b1;
            st_n      = ST_COUNT;
          end else if (lc >= to_lim) begin
            fire    = 1'b1;
            clr_now = 1'b1;
            st_n    = ST_COUNT;
          end
        end
        default: st_n = ST_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_COUNT;
      seen_q     <= 1'b0;
      vsync_out  <= 1'b0;
      field_50hz <= 1'b1;
    end else begin
      st_q      <= st_n;
      seen_q    <= seen_n;
      vsync_out <= fire;
      if (rate_force)    field_50hz <= rate_force_50hz;
      else if (pick_vld) field_50hz <= rate_pick;
    end
  end

endmodule

// File: rtl/vdiv_norm.sv
module vdiv_norm
  import vdiv_pkg::*;
#(
  parameter int LC_W       = 10,
  parameter int CNT_W      = 4,
  parameter int NORM_MIN   = 12,
  parameter int NEAR_MIN   = 6,
  parameter int COUNT_EXIT = 488,
  parameter int NORM_AT_50 = 626,
  parameter int NORM_AT_60 = 526,
  parameter int WIN_LO_50  = 622,
  parameter int WIN_HI_50  = 628,
  parameter int WIN_LO_60  = 522,
  parameter int WIN_HI_60  = 528,
  parameter int TO_LOCK_50 = 722,
  parameter int TO_LOCK_60 = 576,
  parameter int RATE_SPLIT = 576
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line2x_en,
  input  logic vsync_in,
  input  logic hlock,
  input  logic rate_force,
  input  logic rate_force_50hz,
  input  logic wide_hold,
  output logic vsync_out,
  output logic field_50hz,
  output logic norm_lock
);

  logic [LC_W-1:0] lc;
  logic            ev, clr_now, clr_late, fire, good;
  vd_grade_e       grade;

  vdiv_vsync_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (line2x_en),
    .vsync_in (vsync_in),
    .ev       (ev)
  );

  vdiv_line_ctr #(.LC_W(LC_W)) u_lc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (line2x_en),
    .clr_now  (clr_now),
    .clr_late (clr_late),
    .lc       (lc)
  );

  vdiv_norm_grader #(
    .CNT_W    (CNT_W),
    .NORM_MIN (NORM_MIN),
    .NEAR_MIN (NEAR_MIN)
  ) u_grade (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .good      (good),
    .hlock     (hlock),
    .wide_hold (wide_hold),
    .grade     (grade),
    .norm_lock (norm_lock)
  );

  vdiv_ctrl #(
    .LC_W       (LC_W),
    .COUNT_EXIT (COUNT_EXIT),
    .NORM_AT_50 (NORM_AT_50),
    .NORM_AT_60 (NORM_AT_60),
    .WIN_LO_50  (WIN_LO_50),
    .WIN_HI_50  (WIN_HI_50),
    .WIN_LO_60  (WIN_LO_60),
    .WIN_HI_60  (WIN_HI_60),
    .TO_LOCK_50 (TO_LOCK_50),
    .TO_LOCK_60 (TO_LOCK_60),
    .RATE_SPLIT (RATE_SPLIT)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (line2x_en),
    .ev              (ev),
    .lc              (lc),
    .grade           (grade),
    .hlock           (hlock),
    .rate_force      (rate_force),
    .rate_force_50hz (rate_force_50hz),
    .clr_now         (clr_now),
    .clr_late        (clr_late),
    .fire            (fire),
    .good            (good),
    .vsync_out       (vsync_out),
    .field_50hz      (field_50hz)
  );

endmodule

// File: rtl/vdiv_norm_chk.sv
module vdiv_norm_chk (
  input logic clk,
  input logic rst_n,
  input logic line2x_en,
  input logic hlock,
  input logic rate_force,
  input logic rate_force_50hz,
  input logic wide_hold,
  input logic vsync_out,
  input logic field_50hz,
  input logic norm_lock
);

  assert_pulse_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |-> $past(line2x_en));

  assert_pulse_one_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |=> !vsync_out);

  assert_lock_loss_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hlock |=> !norm_lock);

  assert_wide_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wide_hold |=> !norm_lock);

  assert_forced_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_force |=> (field_50hz == $past(rate_force_50hz)));

  assert_lock_rises_at_field_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(norm_lock) |-> vsync_out);

  assert_lock_steady_between_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_out && $past(hlock) && !$past(wide_hold)) |-> $stable(norm_lock));

endmodule

bind vdiv_norm vdiv_norm_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .line2x_en       (line2x_en),
  .hlock           (hlock),
  .rate_force      (rate_force),
  .rate_force_50hz (rate_force_50hz),
  .wide_hold       (wide_hold),
  .vsync_out       (vsync_out),
  .field_50hz      (field_50hz),
  .norm_lock       (norm_lock)
);

// File: tb/vdiv_norm_tb.sv
module vdiv_norm_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line2x_en = 1'b0;
  logic vsync_in = 1'b0;
  logic hlock = 1'b1;
  logic rate_force = 1'b0;
  logic rate_force_50hz = 1'b0;
  logic wide_hold = 1'b0;
  logic vsync_out, field_50hz, norm_lock;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int tick_cnt = 0;
  int pulse_t [0:63];
  int pulse_n = 0;

  always #2 clk = ~clk;

  vdiv_norm u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .line2x_en       (line2x_en),
    .vsync_in        (vsync_in),
    .hlock           (hlock),
    .rate_force      (rate_force),
    .rate_force_50hz (rate_force_50hz),
    .wide_hold       (wide_hold),
    .vsync_out       (vsync_out),
    .field_50hz      (field_50hz),
    .norm_lock       (norm_lock)
  );

  always @(posedge clk) begin
    if (!rst_n)         tick_cnt <= 0;
    else if (line2x_en) tick_cnt <= tick_cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) pulse_n = 0;
    else if (vsync_out && pulse_n < 64) begin
      pulse_t[pulse_n] = tick_cnt;
      pulse_n++;
    end
  end

  // row: period[20:11] fields[10:6] hlock[5] wide_hold[4] force[3] force50[2] exp_lock[1] exp_50[0]
  localparam int NROWS = 11;
  localparam logic [20:0] ROWS [NROWS] = '{
    {10'd628, 5'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6: one field short
    {10'd628, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R2 R6: lock at 12
    {10'd528, 5'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R7: penalty delays lock
    {10'd528, 5'd14, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 R10: 60 Hz lock
    {10'd628, 5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R8: no line lock
    {10'd628, 5'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R8: wide hold
    {10'd600, 5'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R10: late sync, off window
    {10'd628, 5'd4,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R9: forced 60
    {10'd528, 5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R9: forced 50 on 60 Hz input
    {10'd625, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5: count 623, inside
    {10'd624, 5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}   // R5: count 622, outside
  };

  task automatic check(input int act, input int exp, input string req, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic vs);
    @(negedge clk);
    vsync_in  = vs;
    line2x_en = 1'b1;
    @(negedge clk);
    line2x_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  // syncs at strobe P-1, then every P strobes, each held 4 strobes; 4 strobes after the last
  task automatic run_syncs(input int p, input int n);
    int last_t;
    last_t = (p - 1) + (n - 1) * p + 4;
    for (int t = 1; t <= last_t; t++) begin
      int rel;
      rel = t - (p - 1);
      tick(rel >= 0 && (rel / p) < n && (rel % p) < 4);
    end
    vsync_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    line2x_en = 1'b0;
    vsync_in  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // reset state (R10, R1)
    do_reset();
    @(negedge clk);
    check(field_50hz, 1, "R10", "reset rate");
    check(norm_lock, 0, "R10", "reset lock");
    check(vsync_out, 0, "R1", "reset pulse");

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      hlock           = ROWS[r][5];
      wide_hold       = ROWS[r][4];
      rate_force      = ROWS[r][3];
      rate_force_50hz = ROWS[r][2];
      do_reset();
      run_syncs(int'(ROWS[r][20:11]), int'(ROWS[r][10:6]));
      check(norm_lock, int'(ROWS[r][1]), $sformatf("R6 row%0d", r), "norm_lock");
      check(field_50hz, int'(ROWS[r][0]), $sformatf("R10 row%0d", r), "field_50hz");
    end
    hlock = 1'b1; wide_hold = 1'b0; rate_force = 1'b0;

    // R8: lock loss after reaching flywheel confidence
    do_reset();
    run_syncs(628, 12);
    check(norm_lock, 1, "R8", "lock before drop");
    @(negedge clk); hlock = 1'b0;
    @(negedge clk); @(negedge clk);
    check(norm_lock, 0, "R8", "lock after line lock lost");
    hlock = 1'b1;
    @(negedge clk); @(negedge clk);
    check(norm_lock, 0, "R8", "level stays cleared");

    // flywheel dropout: level 14 then no input sync
    do_reset();
    run_syncs(628, 14);
    check(norm_lock, 1, "R6", "level 14 locked");
    idle(626);
    check(norm_lock, 1, "R6", "after one miss (14->12)");
    idle(628);
    check(norm_lock, 0, "R6", "after two misses (12->10)");
    idle(4000);
    check(pulse_n >= 22 ? 1 : 0, 1, "R2", "pulse count");
    if (pulse_n >= 22) begin
      check(pulse_t[14] - pulse_t[13], 628, "R2", "flywheel interval");
      check(pulse_t[15] - pulse_t[14], 628, "R2", "second flywheel interval");
      check(pulse_t[16] - pulse_t[15], 630, "R3", "window timeout after flywheel");
      check(pulse_t[17] - pulse_t[16], 629, "R3", "window timeout repeat");
      check(pulse_t[21] - pulse_t[20], 723, "R4", "locked wide timeout 50 Hz");
    end

    // R4: unlocked wide search, 50 Hz
    hlock = 1'b0;
    do_reset();
    idle(1300);
    check(pulse_n >= 2 ? pulse_t[1] - pulse_t[0] : -1, 629, "R4", "unlocked 50 Hz timeout");

    // R4: unlocked wide search, forced 60 Hz
    rate_force = 1'b1; rate_force_50hz = 1'b0;
    do_reset();
    idle(1100);
    check(pulse_n >= 2 ? pulse_t[1] - pulse_t[0] : -1, 529, "R4", "unlocked 60 Hz timeout");
    check(field_50hz, 0, "R9", "forced 60 held");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 199000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule